// File: doc/BRIEF.md
# Routed Priority Interrupt Controller

This block collects a set of peripheral interrupt inputs and presents one request to a CPU. A programmable routing register for each input names the controller entry that input drives. A value of zero leaves the input connected to nothing. Every entry is one 32-bit word with four bytes: a pending flag, an enable flag, an attribute byte and a control byte. The attribute byte selects level or edge detection and the active polarity. The control byte holds a three-bit urgency level.

The controller selects the enabled, pending entry with the highest level. A global threshold byte then holds back any winner whose control byte is lower than the threshold. The result is registered and appears as a request line, the winning entry index and its level. Software reaches all state over a simple 32-bit register port with byte strobes and combinational read data. The address windows are: routing registers at byte address 0x000 + 4*s, threshold at 0x400, entry n at 0x800 + 4*n. Peripheral lines normally use entries 17 to 47, one entry above line number plus 16.

Top module: `irqrt_ctrl`

## Requirements
- R1: After reset, irq_o, irq_id_o and irq_level_o are 0; every routing register and the threshold register read 0; every entry word reads 0x00C0_0000 (attribute mode bits [23:22] = 11, all else 0).
- R2: A routing register stores only write-data bits [5:0], and only when byte strobe 0 is set; other bits and strobes have no effect and read back as 0.
- R3: Entry word layout: bit 0 pending, bit 8 enable, bits [23:22] mode, bits [18:17] trigger, bit 16 vector flag, bits [31:29] level. All other bits read 0. Each byte lane is written only when its strobe is set.
- R4: Trigger 00 (level, active high): pending follows the synchronized, routed input and drops when the input drops. Software writes to the pending byte have no effect in the level modes.
- R5: Trigger 10 (level, active low): pending is set while the routed input is low.
- R6: Trigger 01 (rising edge): pending latches on a rising input and stays set after the input falls. It is cleared by writing 0 to byte 0. A byte-0 write of 1 sets it.
- R7: Trigger 11 (falling edge): pending latches on a falling input. A rising input does not set it.
- R8: Clearing the enable bit removes the entry from delivery but keeps its pending bit and the routing registers unchanged. Setting it again restores delivery.
- R9: Among entries with pending and enable both set, the highest level wins. On equal levels the lower index wins. irq_id_o and irq_level_o report the winner.
- R10: The threshold register keeps write-data bits [31:24] (strobe 3) and reads 0 in bits [23:0]. A request is issued only when {level,5'b0} >= threshold, so 0x00 passes every level.
- R11: Inputs routed to the same entry are combined by OR after polarity adjustment.
- R12: An input change applied before clock edge k appears on irq_o after edge k+3 (two synchronizer stages, pending, output register). A pending change applied at edge k appears after edge k+1.
- R13: Entry 0 never becomes pending and never raises a request. Routing values that name no existing entry drive nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_i | input | NUM_SRC | Asynchronous peripheral interrupt inputs |
| bus_wr_i | input | 1 | Register write strobe, one cycle per write |
| bus_addr_i | input | ADDR_W | Register byte address |
| bus_be_i | input | 4 | Byte-lane write enables |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Combinational read data for bus_addr_i |
| irq_o | output | 1 | Request to the CPU |
| irq_id_o | output | 6 | Winning entry index, 0 when idle |
| irq_level_o | output | 3 | Winning entry level, 0 when idle |

## Verification
The bench uses the default parameters: four inputs, 48 entries and a 12-bit address. Four inputs are enough to route two inputs onto one entry while other inputs exercise each trigger and polarity. The full 48-entry array makes entry 47 reachable, so the tie-break and top-index cases can be tested. A routing value of 48 names no entry, so the out-of-range case is covered too. Edge entries also let software set pending bits directly, which drives arbitration and threshold cases without toggling inputs.

// File: rtl/irqrt_pkg.sv
// Shared constants and the per-entry state record for the routed
// interrupt controller. Assumes at most 64 entries (6-bit routing values).
package irqrt_pkg;
    localparam int MAP_W = 6;

    // Trigger field encodings: bit 1 = active low, bit 0 = edge detect
    localparam logic [1:0] TRIG_LVL_HI = 2'b00;
    localparam logic [1:0] TRIG_RISE   = 2'b01;
    localparam logic [1:0] TRIG_LVL_LO = 2'b10;
    localparam logic [1:0] TRIG_FALL   = 2'b11;

    // Address windows, selected by the top two address bits
    localparam logic [1:0] WIN_MAP = 2'b00;
    localparam logic [1:0] WIN_THR = 2'b01;
    localparam logic [1:0] WIN_ENT = 2'b10;

    typedef struct packed {
        logic       pend;
        logic       en;
        logic [1:0] mode;
        logic [1:0] trig;
        logic       shv;
        logic [2:0] prio;
    } entry_t;
endpackage

// File: rtl/irqrt_sync.sv
// Two-stage synchronizer for the asynchronous interrupt inputs.
// Assumes each input is held long enough to be seen by two clock edges.
module irqrt_sync #(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    logic [WIDTH-1:0] meta_q;
    logic [WIDTH-1:0] stab_q;

    // Shift each input through two flops
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '0;
            stab_q <= '0;
        end else begin
            meta_q <= async_i;
            stab_q <= meta_q;
        end
    end

    assign sync_o = stab_q;
endmodule

// File: rtl/irqrt_arbiter.sv
// Combinational priority pick across all entries: highest level wins,
// lowest index on a tie. The clock is used only by the assertions.
module irqrt_arbiter #(
    parameter int NUM_ENTRY = 48,
    parameter int IDX_W     = 6
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NUM_ENTRY-1:0]      elig,
    input  logic [NUM_ENTRY-1:0][2:0] prio,
    output logic                      win_vld,
    output logic [IDX_W-1:0]          win_idx,
    output logic [2:0]                win_prio
);
    // Scan from the top index down; ">=" lets a lower index take a tie
    always_comb begin
        win_vld  = 1'b0;
        win_idx  = '0;
        win_prio = '0;
        for (int e = NUM_ENTRY - 1; e >= 0; e--) begin
            if (elig[e] && (!win_vld || prio[e] >= win_prio)) begin
                win_vld  = 1'b1;
                win_idx  = IDX_W'(e);
                win_prio = prio[e];
            end
        end
    end

    a_r9_winner_eligible: assert property (@(posedge clk) disable iff (!rst_n)
        win_vld |-> ((elig >> win_idx) & NUM_ENTRY'(1)) != '0);
    a_r9_idle_when_none: assert property (@(posedge clk) disable iff (!rst_n)
        !win_vld |-> elig == '0);
endmodule

// File: rtl/irqrt_ctrl.sv
// Routed interrupt controller top. Each input has a routing register that
// names an entry; entries detect level or edge with a polarity, hold
// pending/enable/attribute/level, and are arbitrated and threshold-gated
// into one registered request. Assumes NUM_ENTRY <= 64 and
// NUM_ENTRY, NUM_SRC <= 2**(ADDR_W-4).
module irqrt_ctrl
    import irqrt_pkg::*;
#(
    parameter int NUM_SRC   = 4,
    parameter int NUM_ENTRY = 48,
    parameter int ADDR_W    = 12
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_i,
    input  logic               bus_wr_i,
    input  logic [ADDR_W-1:0]  bus_addr_i,
    input  logic [3:0]         bus_be_i,
    input  logic [31:0]        bus_wdata_i,
    output logic [31:0]        bus_rdata_o,
    output logic               irq_o,
    output logic [5:0]         irq_id_o,
    output logic [2:0]         irq_level_o
);
    localparam int WORD_W = ADDR_W - 4;

    logic [1:0]        win_sel;
    logic [WORD_W-1:0] word_sel;
    assign win_sel  = bus_addr_i[ADDR_W-1 -: 2];
    assign word_sel = bus_addr_i[ADDR_W-3:2];

    logic [NUM_SRC-1:0]              src_s;
    logic [NUM_SRC-1:0][MAP_W-1:0]   map_q;
    logic [7:0]                      thr_q;
    logic [NUM_ENTRY-1:0]            elig;
    logic [NUM_ENTRY-1:0][2:0]       prio;
    logic [NUM_ENTRY-1:0][31:0]      ent_rd;

    irqrt_sync #(.WIDTH(NUM_SRC)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .async_i(src_i),
        .sync_o (src_s)
    );

    // Routing registers: low six bits of byte lane 0
    for (genvar s = 0; s < NUM_SRC; s++) begin : g_map
        always_ff @(posedge clk) begin
            if (!rst_n)
                map_q[s] <= '0;
            else if (bus_wr_i && win_sel == WIN_MAP && word_sel == WORD_W'(s) && bus_be_i[0])
                map_q[s] <= bus_wdata_i[MAP_W-1:0];
        end
    end

    // Threshold register: byte lane 3 only
    always_ff @(posedge clk) begin
        if (!rst_n)
            thr_q <= '0;
        else if (bus_wr_i && win_sel == WIN_THR && word_sel == '0 && bus_be_i[3])
            thr_q <= bus_wdata_i[31:24];
    end

    for (genvar e = 0; e < NUM_ENTRY; e++) begin : g_ent
        entry_t q;
        logic   lvl;
        logic   prev_q;
        logic   wr_sel;

        assign wr_sel = bus_wr_i && win_sel == WIN_ENT && word_sel == WORD_W'(e);

        // OR of polarity-adjusted inputs routed here; entry 0 takes none
        always_comb begin
            lvl = 1'b0;
            for (int s = 0; s < NUM_SRC; s++) begin
                if (e != 0 && map_q[s] == MAP_W'(e))
                    lvl = lvl | (src_s[s] ^ q.trig[1]);
            end
        end

        // Entry state: configuration bytes, edge history and pending bit
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                q      <= '{pend: 1'b0, en: 1'b0, mode: 2'b11, trig: TRIG_LVL_HI, shv: 1'b0, prio: 3'd0};
                prev_q <= 1'b0;
            end else begin
                prev_q <= lvl;
                if (wr_sel && bus_be_i[1]) q.en <= bus_wdata_i[8];
                if (wr_sel && bus_be_i[2]) begin
                    q.mode <= bus_wdata_i[23:22];
                    q.trig <= bus_wdata_i[18:17];
                    q.shv  <= bus_wdata_i[16];
                end
                if (wr_sel && bus_be_i[3]) q.prio <= bus_wdata_i[31:29];
                if (e == 0)
                    q.pend <= 1'b0;
                else if (!q.trig[0])
                    q.pend <= lvl;
                else if (lvl && !prev_q)
                    q.pend <= 1'b1;
                else if (wr_sel && bus_be_i[0])
                    q.pend <= bus_wdata_i[0];
            end
        end

        assign elig[e]   = q.pend & q.en;
        assign prio[e]   = q.prio;
        assign ent_rd[e] = {q.prio, 5'b0, q.mode, 3'b0, q.trig, q.shv, 7'b0, q.en, 7'b0, q.pend};
    end

    logic             win_vld;
    logic [MAP_W-1:0] win_idx;
    logic [2:0]       win_prio;

    irqrt_arbiter #(.NUM_ENTRY(NUM_ENTRY), .IDX_W(MAP_W)) u_arb (
        .clk     (clk),
        .rst_n   (rst_n),
        .elig    (elig),
        .prio    (prio),
        .win_vld (win_vld),
        .win_idx (win_idx),
        .win_prio(win_prio)
    );

    // Output stage: threshold gate, then register the winner
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_o       <= 1'b0;
            irq_id_o    <= '0;
            irq_level_o <= '0;
        end else if (win_vld && {win_prio, 5'b0} >= thr_q) begin
            irq_o       <= 1'b1;
            irq_id_o    <= win_idx;
            irq_level_o <= win_prio;
        end else begin
            irq_o       <= 1'b0;
            irq_id_o    <= '0;
            irq_level_o <= '0;
        end
    end

    // Read multiplexer over the three windows
    always_comb begin
        bus_rdata_o = '0;
        case (win_sel)
            WIN_MAP: for (int s = 0; s < NUM_SRC; s++)
                         if (word_sel == WORD_W'(s)) bus_rdata_o = {{(32-MAP_W){1'b0}}, map_q[s]};
            WIN_THR: if (word_sel == '0) bus_rdata_o = {thr_q, 24'b0};
            WIN_ENT: for (int e = 0; e < NUM_ENTRY; e++)
                         if (word_sel == WORD_W'(e)) bus_rdata_o = ent_rd[e];
            default: bus_rdata_o = '0;
        endcase
    end

    a_r1_idle_outputs_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_o |-> (irq_id_o == '0 && irq_level_o == '0));
    a_r10_threshold_respected: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> {irq_level_o, 5'b0} >= $past(thr_q));
    a_r12_one_cycle_from_pending: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (($past(elig) >> irq_id_o) & NUM_ENTRY'(1)) != '0);
    a_r13_null_entry_silent: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> irq_id_o != '0);
    a_r3_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (win_sel == WIN_ENT) |-> (bus_rdata_o[28:24] == '0 && bus_rdata_o[21:19] == '0 &&
                                  bus_rdata_o[15:9] == '0 && bus_rdata_o[7:1] == '0));
endmodule

// File: tb/irqrt_ctrl_tb.sv
// Directed bench for irqrt_ctrl: one task per scenario, each checking itself.
module irqrt_ctrl_tb;
    localparam int NS = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [NS-1:0] src = '0;
    logic        wr = 1'b0;
    logic [11:0] addr = '0;
    logic [3:0]  be = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq;
    logic [5:0]  irq_id;
    logic [2:0]  irq_lvl;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    irqrt_ctrl #(.NUM_SRC(NS), .NUM_ENTRY(48), .ADDR_W(12)) u_dut (
        .clk(clk), .rst_n(rst_n), .src_i(src),
        .bus_wr_i(wr), .bus_addr_i(addr), .bus_be_i(be), .bus_wdata_i(wdata),
        .bus_rdata_o(rdata), .irq_o(irq), .irq_id_o(irq_id), .irq_level_o(irq_lvl)
    );

    function automatic logic [11:0] ent_a(int e); return 12'h800 + 12'(4 * e); endfunction
    function automatic logic [11:0] map_a(int s); return 12'(4 * s); endfunction
    localparam logic [11:0] THR_A = 12'h400;

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
        end
    endtask

    task automatic chk_irq(string tag, logic e_irq, logic [5:0] e_id, logic [2:0] e_lvl);
        chk(tag, {22'b0, irq, irq_id, irq_lvl}, {22'b0, e_irq, e_id, e_lvl});
    endtask

    task automatic settle(int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic bus_write(logic [11:0] a, logic [3:0] b, logic [31:0] d);
        @(negedge clk);
        wr = 1'b1; addr = a; be = b; wdata = d;
        @(posedge clk);
        @(negedge clk);
        wr = 1'b0; be = '0;
    endtask

    task automatic bus_read(logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        addr = a;
        #1 d = rdata;
    endtask

    // Configure trigger, level and enable; leaves pending byte untouched
    task automatic cfg(int e, logic [1:0] trig, logic [2:0] p, logic en);
        bus_write(ent_a(e), 4'b1110, {p, 5'b0, 2'b11, 3'b0, trig, 1'b0, 7'b0, en, 8'h00});
    endtask

    task automatic clear_entry(int e);
        bus_write(ent_a(e), 4'b1111, 32'h0);
    endtask

    task automatic t_reset();
        logic [31:0] d;
        chk_irq("R1 outputs after reset", 1'b0, 6'd0, 3'd0);
        bus_read(map_a(0), d);  chk("R1 map reset", d, 32'h0);
        bus_read(THR_A, d);     chk("R1 threshold reset", d, 32'h0);
        bus_read(ent_a(17), d); chk("R1 entry reset", d, 32'h00C0_0000);
    endtask

    task automatic t_map();
        logic [31:0] d;
        bus_write(map_a(0), 4'b1111, 32'hFFFF_FFD1);
        bus_read(map_a(0), d); chk("R2 map keeps low six bits", d, 32'd17);
        bus_write(map_a(0), 4'b1110, 32'h0000_0000);
        bus_read(map_a(0), d); chk("R2 map ignores other strobes", d, 32'd17);
        bus_write(map_a(0), 4'b0001, 32'h0);
        bus_read(map_a(0), d); chk("R2 map cleared", d, 32'd0);
    endtask

    task automatic t_layout();
        logic [31:0] d;
        bus_write(ent_a(20), 4'b1111, 32'hFFFF_FFFF);
        bus_read(ent_a(20), d); chk("R3 full write layout", d, 32'hE0C7_0100);
        bus_write(ent_a(20), 4'b0001, 32'h0000_0001);
        bus_read(ent_a(20), d); chk("R6 software set in edge mode", d, 32'hE0C7_0101);
        clear_entry(20);
        bus_read(ent_a(20), d); chk("R3 cleared entry", d, 32'h0);
        bus_write(ent_a(20), 4'b1000, 32'hBFFF_FFFF);
        bus_read(ent_a(20), d); chk("R3 single lane strobe", d, 32'hA000_0000);
        clear_entry(20);
        settle(2);
        chk_irq("R3 no request after layout test", 1'b0, 6'd0, 3'd0);
    endtask

    task automatic t_level_hi();
        logic [31:0] d;
        cfg(17, 2'b00, 3'd3, 1'b1);
        bus_write(map_a(0), 4'b0001, 32'd17);
        bus_write(ent_a(17), 4'b0001, 32'h1);
        bus_read(ent_a(17), d); chk("R4 pending write ignored in level mode", d & 32'h1, 32'h0);
        @(negedge clk); src[0] = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk); chk_irq("R12 not yet after three edges", 1'b0, 6'd0, 3'd0);
        @(posedge clk);
        @(negedge clk); chk_irq("R12 request after fourth edge", 1'b1, 6'd17, 3'd3);
        bus_read(ent_a(17), d); chk("R4 pending follows input", d & 32'h1, 32'h1);
        src[0] = 1'b0;
        settle(5);
        chk_irq("R4 request drops with input", 1'b0, 6'd0, 3'd0);
        bus_read(ent_a(17), d); chk("R4 pending drops", d & 32'h1, 32'h0);
        clear_entry(17);
    endtask

    task automatic t_level_lo();
        cfg(18, 2'b10, 3'd2, 1'b1);
        bus_write(map_a(1), 4'b0001, 32'd18);
        settle(3);
        chk_irq("R5 active low input idle low requests", 1'b1, 6'd18, 3'd2);
        src[1] = 1'b1;
        settle(5);
        chk_irq("R5 high input is inactive", 1'b0, 6'd0, 3'd0);
        clear_entry(18);
        bus_write(map_a(1), 4'b0001, 32'd0);
        src[1] = 1'b0;
    endtask

    task automatic t_rise();
        logic [31:0] d;
        cfg(19, 2'b01, 3'd4, 1'b1);
        bus_write(map_a(2), 4'b0001, 32'd19);
        settle(4);
        chk_irq("R6 no edge no request", 1'b0, 6'd0, 3'd0);
        src[2] = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk); chk_irq("R12 edge not yet", 1'b0, 6'd0, 3'd0);
        @(posedge clk);
        @(negedge clk); chk_irq("R12 edge request on fourth edge", 1'b1, 6'd19, 3'd4);
        src[2] = 1'b0;
        settle(5);
        chk_irq("R6 pending held after input falls", 1'b1, 6'd19, 3'd4);
        bus_write(ent_a(19), 4'b0001, 32'h0);
        bus_read(ent_a(19), d); chk("R6 pending cleared by write", d & 32'h1, 32'h0);
        settle(1);
        chk_irq("R6 request gone after clear", 1'b0, 6'd0, 3'd0);
        clear_entry(19);
        bus_write(map_a(2), 4'b0001, 32'd0);
    endtask

    task automatic t_fall_enable();
        logic [31:0] d;
        src[3] = 1'b1;
        cfg(21, 2'b11, 3'd1, 1'b1);
        settle(3);
        bus_write(map_a(3), 4'b0001, 32'd21);
        settle(3);
        chk_irq("R7 high idle no request", 1'b0, 6'd0, 3'd0);
        src[3] = 1'b0;
        settle(5);
        chk_irq("R7 falling edge requests", 1'b1, 6'd21, 3'd1);
        bus_write(ent_a(21), 4'b0001, 32'h0);
        src[3] = 1'b1;
        settle(5);
        chk_irq("R7 rising edge ignored", 1'b0, 6'd0, 3'd0);
        src[3] = 1'b0;
        settle(5);
        bus_write(ent_a(21), 4'b0010, 32'h0);
        settle(1);
        chk_irq("R8 disabled entry not delivered", 1'b0, 6'd0, 3'd0);
        bus_read(ent_a(21), d); chk("R8 pending kept while disabled", d & 32'h101, 32'h1);
        bus_read(map_a(3), d);  chk("R8 routing kept while disabled", d, 32'd21);
        bus_write(ent_a(21), 4'b0010, 32'h100);
        settle(1);
        chk_irq("R8 re-enable restores delivery", 1'b1, 6'd21, 3'd1);
        clear_entry(21);
        bus_write(map_a(3), 4'b0001, 32'd0);
    endtask

    task automatic t_arb();
        cfg(30, 2'b01, 3'd5, 1'b1);
        cfg(25, 2'b01, 3'd5, 1'b1);
        cfg(40, 2'b01, 3'd6, 1'b1);
        cfg(47, 2'b01, 3'd7, 1'b1);
        bus_write(ent_a(30), 4'b0001, 32'h1);
        bus_write(ent_a(25), 4'b0001, 32'h1);
        settle(1);
        chk_irq("R9 tie goes to lower index", 1'b1, 6'd25, 3'd5);
        bus_write(ent_a(40), 4'b0001, 32'h1);
        settle(1);
        chk_irq("R9 higher level wins", 1'b1, 6'd40, 3'd6);
        bus_write(ent_a(47), 4'b0001, 32'h1);
        settle(1);
        chk_irq("R9 top entry 47", 1'b1, 6'd47, 3'd7);
        bus_write(ent_a(47), 4'b0001, 32'h0);
        bus_write(ent_a(40), 4'b0001, 32'h0);
        bus_write(ent_a(25), 4'b0001, 32'h0);
        settle(1);
        chk_irq("R9 remaining entry wins", 1'b1, 6'd30, 3'd5);
        clear_entry(25); clear_entry(40); clear_entry(47);
    endtask

    task automatic t_thr();
        logic [31:0] d;
        bus_write(THR_A, 4'b1111, 32'hA0FF_FFFF);
        bus_read(THR_A, d); chk("R10 threshold byte only", d, 32'hA000_0000);
        settle(1);
        chk_irq("R10 equal level passes", 1'b1, 6'd30, 3'd5);
        bus_write(THR_A, 4'b1000, 32'hA100_0000);
        settle(1);
        chk_irq("R10 level below threshold blocked", 1'b0, 6'd0, 3'd0);
        clear_entry(30);
        cfg(31, 2'b01, 3'd0, 1'b1);
        bus_write(ent_a(31), 4'b0001, 32'h1);
        bus_write(THR_A, 4'b1000, 32'h0);
        settle(1);
        chk_irq("R10 zero threshold passes level 0", 1'b1, 6'd31, 3'd0);
        clear_entry(31);
    endtask

    task automatic t_or();
        cfg(33, 2'b00, 3'd2, 1'b1);
        bus_write(map_a(0), 4'b0001, 32'd33);
        bus_write(map_a(2), 4'b0001, 32'd33);
        src[2] = 1'b1;
        settle(5);
        chk_irq("R11 second input alone", 1'b1, 6'd33, 3'd2);
        src[2] = 1'b0; src[0] = 1'b1;
        settle(5);
        chk_irq("R11 first input alone", 1'b1, 6'd33, 3'd2);
        src[0] = 1'b0;
        settle(5);
        chk_irq("R11 both low", 1'b0, 6'd0, 3'd0);
        clear_entry(33);
    endtask

    task automatic t_null();
        logic [31:0] d;
        cfg(0, 2'b01, 3'd7, 1'b1);
        bus_write(ent_a(0), 4'b0001, 32'h1);
        bus_write(map_a(0), 4'b0001, 32'd0);
        bus_write(map_a(1), 4'b0001, 32'd48);
        src[0] = 1'b1; src[1] = 1'b1;
        settle(5);
        chk_irq("R13 entry 0 and index 48 silent", 1'b0, 6'd0, 3'd0);
        bus_read(ent_a(0), d); chk("R13 entry 0 never pending", d & 32'h1, 32'h0);
        src = '0;
        clear_entry(0);
    endtask

    initial begin
        settle(3);
        rst_n = 1'b1;
        settle(1);
        t_reset();
        t_map();
        t_layout();
        t_level_hi();
        t_level_lo();
        t_rise();
        t_fall_enable();
        t_arb();
        t_thr();
        t_or();
        t_null();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule